// File: doc/BRIEF.md
# Programmable Clock Output Controller

This block drives three independent programmable clock outputs for a chip's clock controller. Each output takes one of four source clocks (slow, main, PLL A, PLL B) and divides it by a power of two from 1 to 64. The source clocks reach the block as single-cycle enable pulses on the system clock. Each output leaves the block as a single-cycle enable pulse for every divided period.

Software uses a small register bus. It turns outputs on through a write-one-to-set register and off through a write-one-to-clear register, and it reads which outputs are on. Each output has its own configuration register. That register can be changed only while the output is off. After an output is switched on, a per-output ready flag comes up once two pulses of the chosen source have been seen. The flag stands in for a clock-domain synchronizer. Ready flags can be routed to a single interrupt line through a set/clear interrupt mask.

Top module: `pclk_out_ctrl`

## Requirements
- R1: After reset, all outputs are off, all ready flags and interrupt mask bits read 0, every configuration reads 0 (slow source, divide by 1), `pck_out` is 0 and `irq` is 0.
- R2: A write to address 0x0 turns on each output whose data bit n is 1. Bits that are 0 have no effect. Address 0x2 reads the on/off state in bits [2:0].
- R3: A write to address 0x1 turns off each output whose data bit n is 1. The output's on bit and its ready flag both read 0 from the edge that takes the write, and its `pck_out` bit is 0 in the following cycle.
- R4: Address 0x8+n is output n's configuration. Bits [1:0] select the source: 0 slow, 1 main, 2 PLL A, 3 PLL B (`src_tick` bits 0..3). Bits [6:4] hold the prescaler code. Both fields are written in a single write and read back in the same layout.
- R5: A configuration write to an output that is on is ignored, and the previous settings read back unchanged.
- R6: After an output is turned on, its ready flag (address 0x3, bit n) sets on the second pulse of the selected source. It is visible in the cycle after that pulse. Pulses of unselected sources are not counted.
- R7: Once ready, the output gives a one-cycle `pck_out` pulse after every 2^code-th selected source pulse, for codes 0..6. Code 7 divides by 64. Code 0 divides by 1.
- R8: Turning an output off and then on again restarts the ready count from zero.
- R9: Writes to 0x4 set interrupt mask bits and writes to 0x5 clear them. Address 0x6 reads the mask. `irq` is 1 exactly when some output is both ready and unmasked.
- R10: `pck_out` stays 0 for an output that is off or not yet ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Source pulses: bit0 slow, bit1 main, bit2 PLL A, bit3 PLL B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pck_out | output | 3 | Divided output pulses, one bit per output |
| irq | output | 1 | Interrupt: OR of ready flags gated by the mask |

## Verification
The bench feeds pulses on the unselected sources and checks that the ready flag does not rise. A design that counted every source would report ready too early. It writes a new configuration to an output that is on and reads it back. A design without the lock would change the divider while the output is running. It counts output pulses at divide-by-1, divide-by-8 and the clamped code 7. An off-by-one in the prescaler or a wrapped code would give the wrong count. It also turns an output off and on again, which catches a design that keeps a stale ready flag or synchronizer count.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 4;
  localparam int NUM_SRC       = 4;
  localparam int PRES_MAX_CODE = 6;

  localparam logic [ADDR_W-1:0] ADR_ON     = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_OFF    = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_STATE  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_READY  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_IMSET  = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_IMCLR  = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_IMASK  = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_CFG0   = 4'h8;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLLA = 2'd2,
    SRC_PLLB = 2'd3
  } src_sel_e;

  // Division ratio for a prescaler code; codes above the max clamp.
  function automatic int unsigned div_of_code(input logic [2:0] code);
    int unsigned c;
    c = (int'(code) > PRES_MAX_CODE) ? PRES_MAX_CODE : int'(code);
    return 32'd1 << c;
  endfunction
endpackage

// File: rtl/pclk_chan.sv
module pclk_chan
  import pclk_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_tick,
  input  logic                 set_req,
  input  logic                 clr_req,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_src,
  input  logic [2:0]           cfg_pres,
  output logic                 en_o,
  output logic                 ready_o,
  output logic [1:0]           src_o,
  output logic [2:0]           pres_o,
  output logic                 out_o
);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);
  localparam int CNT_W  = PRES_MAX_CODE;

  logic              en_q, ready_q, out_q;
  src_sel_e          src_q;
  logic [2:0]        pres_q;
  logic [SYNC_W-1:0] sync_cnt;
  logic [CNT_W-1:0]  div_cnt;

  // Named internal events
  logic sel_tick, turn_on, sync_done, div_wrap, cfg_take;
  logic [CNT_W-1:0] div_last;

  assign sel_tick  = src_tick[src_q];
  assign turn_on   = set_req && !en_q;
  assign cfg_take  = cfg_wr && !en_q;
  assign sync_done = en_q && !ready_q && sel_tick &&
                     (sync_cnt == SYNC_W'(SYNC_TICKS - 1));
  assign div_last  = CNT_W'(div_of_code(pres_q) - 1);
  assign div_wrap  = en_q && ready_q && sel_tick && (div_cnt == div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_SLOW;
      pres_q <= '0;
    end else if (cfg_take) begin
      src_q  <= src_sel_e'(cfg_src);
      pres_q <= cfg_pres;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ready_q  <= 1'b0;
      sync_cnt <= '0;
      div_cnt  <= '0;
      out_q    <= 1'b0;
    end else if (clr_req) begin
      en_q     <= 1'b0;
      ready_q  <= 1'b0;
      sync_cnt <= '0;
      div_cnt  <= '0;
      out_q    <= 1'b0;
    end else if (turn_on) begin
      en_q     <= 1'b1;
      ready_q  <= 1'b0;
      sync_cnt <= '0;
      div_cnt  <= '0;
      out_q    <= 1'b0;
    end else begin
      out_q <= div_wrap;
      if (sync_done)
        ready_q <= 1'b1;
      else if (en_q && !ready_q && sel_tick)
        sync_cnt <= sync_cnt + 1'b1;
      if (en_q && ready_q && sel_tick)
        div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
    end
  end

  assign en_o    = en_q;
  assign ready_o = ready_q;
  assign src_o   = src_q;
  assign pres_o  = pres_q;
  assign out_o   = out_q;

  // R5: settings are frozen while the output is on
  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(src_q) && $stable(pres_q)));
  // R3: turning off clears enable, ready and output on the next cycle
  p_off_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!en_q && !ready_q && !out_q));
  // R10: no output pulse unless on and ready
  p_out_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> (en_q && ready_q));
  // R6: ready rises only on a selected source pulse while on
  p_ready_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(sel_tick) && $past(en_q)));
endmodule

// File: rtl/pclk_irq.sv
module pclk_irq #(
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic             clr_req,
  input  logic [N_OUT-1:0] bits,
  input  logic [N_OUT-1:0] ready,
  output logic [N_OUT-1:0] mask_o,
  output logic             irq_o
);
  logic [N_OUT-1:0] mask_q;
  logic [N_OUT-1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (set_req) mask_q <= mask_q | bits;
    else if (clr_req) mask_q <= mask_q & ~bits;
  end

  assign pending = ready & mask_q;
  assign irq_o   = |pending;
  assign mask_o  = mask_q;

  // R9: set and clear writes land on exactly the written bits
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> ((mask_q & $past(bits)) == $past(bits)));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> ((mask_q & $past(bits)) == '0));
endmodule

// File: rtl/pclk_out_ctrl.sv
module pclk_out_ctrl
  import pclk_pkg::*;
#(
  parameter int N_OUT      = 3,
  parameter int SYNC_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [N_OUT-1:0]     pck_out,
  output logic                 irq
);
  localparam int PAD_W = DATA_W - N_OUT;

  logic             wr_on, wr_off, wr_imset, wr_imclr;
  logic [N_OUT-1:0] sel_bits;
  logic [N_OUT-1:0] cfg_wr_vec, en_vec, rdy_vec, mask_vec;
  logic [1:0]       src_a  [N_OUT];
  logic [2:0]       pres_a [N_OUT];

  assign sel_bits = wr_data[N_OUT-1:0];
  assign wr_on    = wr_en && (wr_addr == ADR_ON);
  assign wr_off   = wr_en && (wr_addr == ADR_OFF);
  assign wr_imset = wr_en && (wr_addr == ADR_IMSET);
  assign wr_imclr = wr_en && (wr_addr == ADR_IMCLR);

  for (genvar n = 0; n < N_OUT; n++) begin : g_chan
    assign cfg_wr_vec[n] = wr_en && (wr_addr == ADDR_W'(ADR_CFG0 + n));

    pclk_chan #(.SYNC_TICKS(SYNC_TICKS)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .set_req  (wr_on  && sel_bits[n]),
      .clr_req  (wr_off && sel_bits[n]),
      .cfg_wr   (cfg_wr_vec[n]),
      .cfg_src  (wr_data[1:0]),
      .cfg_pres (wr_data[6:4]),
      .en_o     (en_vec[n]),
      .ready_o  (rdy_vec[n]),
      .src_o    (src_a[n]),
      .pres_o   (pres_a[n]),
      .out_o    (pck_out[n])
    );
  end

  pclk_irq #(.N_OUT(N_OUT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (wr_imset),
    .clr_req (wr_imclr),
    .bits    (sel_bits),
    .ready   (rdy_vec),
    .mask_o  (mask_vec),
    .irq_o   (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_STATE: rd_data = {{PAD_W{1'b0}}, en_vec};
      ADR_READY: rd_data = {{PAD_W{1'b0}}, rdy_vec};
      ADR_IMASK: rd_data = {{PAD_W{1'b0}}, mask_vec};
      default: begin
        for (int k = 0; k < N_OUT; k++)
          if (rd_addr == ADDR_W'(ADR_CFG0 + k))
            rd_data = {1'b0, pres_a[k], 2'b00, src_a[k]};
      end
    endcase
  end

  // R4: at most one configuration register is written per cycle
  always_comb begin
    p_cfg_sel_onehot_r4: assert ($onehot0(cfg_wr_vec));
  end

  // R9: interrupt only when some unmasked output is ready
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rdy_vec & mask_vec) != '0));
endmodule

// File: tb/pclk_out_ctrl_tb.sv
module pclk_out_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] pck_out;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses [3];

  always #4 clk = ~clk;

  pclk_out_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pck_out(pck_out), .irq(irq)
  );

  always @(negedge clk)
    for (int i = 0; i < 3; i++) if (pck_out[i]) pulses[i]++;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1 v = int'(rd_data);
  endtask

  task automatic tick(input int s, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk); src_tick = 4'(1 << s);
      @(negedge clk); src_tick = '0;
    end
  endtask

  function automatic int exp_div(input int code);
    int d = 1;
    for (int i = 0; i < code && i < 6; i++) d = d * 2;
    return d;
  endfunction

  task automatic clear_pulses();
    for (int i = 0; i < 3; i++) pulses[i] = 0;
  endtask

  task automatic t_reset();
    int v;
    rd(4'h2, v); chk("R1 state", v, 0);
    rd(4'h3, v); chk("R1 ready", v, 0);
    rd(4'h6, v); chk("R1 mask", v, 0);
    for (int k = 0; k < 3; k++) begin
      rd(4'(8 + k), v); chk("R1 cfg", v, 0);
    end
    chk("R1 pck_out", int'(pck_out), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_cfg();
    int v;
    wr(4'h9, 8'h31); rd(4'h9, v); chk("R4 cfg1 readback", v, 'h31);
    wr(4'hA, 8'h73); rd(4'hA, v); chk("R4 cfg2 readback", v, 'h73);
  endtask

  task automatic t_ready0();
    int v;
    wr(4'h0, 8'h01);
    rd(4'h2, v); chk("R2 on ch0", v, 1);
    tick(1, 2); tick(2, 1);
    rd(4'h3, v); chk("R6 unselected ignored", v, 0);
    tick(0, 1);
    rd(4'h3, v); chk("R6 not ready after one", v, 0);
    chk("R10 no pulse before ready", pulses[0], 0);
    tick(0, 1);
    rd(4'h3, v); chk("R6 ready after two", v, 1);
  endtask

  task automatic t_locked();
    int v;
    wr(4'h8, 8'h23);
    rd(4'h8, v); chk("R5 cfg write ignored", v, 0);
  endtask

  task automatic t_div0();
    int v;
    clear_pulses();
    tick(0, 64);
    @(negedge clk);
    chk("R7 div1 count", pulses[0], 64 / exp_div(0));
    wr(4'h1, 8'h01);
    rd(4'h2, v); chk("R3 off state", v, 0);
    rd(4'h3, v); chk("R3 ready cleared", v, 0);
    chk("R3 output low", int'(pck_out[0]), 0);
    clear_pulses();
    tick(0, 8);
    chk("R10 off no pulse", pulses[0], 0);
  endtask

  task automatic t_div1();
    int v;
    wr(4'h0, 8'h02);
    rd(4'h2, v); chk("R2 zero bits no effect", v, 2);
    tick(1, 2);
    clear_pulses();
    tick(1, 64);
    @(negedge clk);
    chk("R7 div8 count", pulses[1], 64 / exp_div(3));
  endtask

  task automatic t_div2();
    wr(4'h0, 8'h04);
    tick(3, 2);
    clear_pulses();
    tick(3, 128);
    @(negedge clk);
    chk("R7 code7 clamps to 64", pulses[2], 128 / exp_div(7));
  endtask

  task automatic t_reenable();
    int v;
    wr(4'h1, 8'h02);
    wr(4'h0, 8'h02);
    tick(1, 1);
    rd(4'h3, v); chk("R8 restart count", v & 2, 0);
    tick(1, 1);
    rd(4'h3, v); chk("R8 ready again", v & 2, 2);
  endtask

  task automatic t_irq();
    int v;
    chk("R9 irq masked", int'(irq), 0);
    wr(4'h4, 8'h02);
    rd(4'h6, v); chk("R9 mask set", v, 2);
    chk("R9 irq raised", int'(irq), 1);
    wr(4'h5, 8'h02);
    rd(4'h6, v); chk("R9 mask cleared", v, 0);
    chk("R9 irq dropped", int'(irq), 0);
    wr(4'h4, 8'h01);
    chk("R9 not-ready unmasked", int'(irq), 0);
  endtask

  initial begin
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_ready0();
    t_locked();
    t_div0();
    t_div1();
    t_div2();
    t_reenable();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule